// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block is the host-side engine that erases a single 16 KB block of an 8-bit NAND flash device. A one-cycle start pulse together with a 10-bit block number launches the full erase handshake. The sequencer sends the setup command, then two address bytes, then the confirm command. It then watches the device's ready/busy line until the internal erase has run. Finally it fetches the status byte and reports the outcome.

All device strobes are generated here: command latch, address latch, chip enable, write enable and read enable. The 8-bit data bus is split into a driven output, an output-enable and a sampled input, so the pad ring can build the bidirectional pin. Strobe widths and the busy timeout are counted in clock cycles, so one netlist can serve several device speeds. When the erase ends, a single-cycle `done_o` pulse is raised. Alongside it come pass, write-protect and timeout flags, and these hold their values until the next accepted start.

Top module: `nand_erase_seq`

## Requirements
- R1: After reset and whenever `busy_o` is low, CE#, WE# and RE# are high, CLE, ALE and `io_oe_o` are low, and `done_o` is low.
- R2: A start accepted while idle latches `blk_i`, raises `busy_o` and issues command byte 0x60 with CLE=1 and ALE=0. CE# stays low whenever WE# or RE# is low, and CLE and ALE are never high together.
- R3: Two address cycles (ALE=1, CLE=0) follow the setup command. The first byte is {blk[2:0], 5'b00000}, i.e. bits 7:5 carry address bits 14..16 and the five low bits (address bits 9..13) are zero. The second byte is {1'b0, blk[9:3]}.
- R4: The confirm command 0xD0 follows the address cycles. Each write cycle holds WE# low for exactly WE_LO cycles with `io_oe_o` high and the byte stable, then returns WE# high for STB_HI cycles. WE# and RE# are never low together.
- R5: After the confirm byte the sequencer waits for the synchronised ready line to go low and then high. It then writes command 0x70 and performs exactly one read cycle, in which RE# is low for RE_LO cycles and `io_oe_o` is low.
- R6: Status decode: `pass_o`=1 only when status bit 0 is 0 and bit 6 is 1. `wp_o`=1 when status bit 7 is 0 (device protected).
- R7: If ready has not gone low and then high within TO_CYC cycles of entering the wait, the operation ends with `timeout_o`=1, `pass_o`=0 and `wp_o`=0. No status command or read cycle is issued.
- R8: A start pulse while `busy_o` is high is ignored: the bytes sent and the number of completions are unchanged.
- R9: `done_o` is high for exactly one cycle per accepted start, with the flags valid in that cycle. The flags hold until the next accepted start, which clears them in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| blk_i | input | 10 | Block number to erase |
| rdy_i | input | 1 | Device ready/busy line (1 = ready) |
| io_i | input | 8 | Data bus input from the device |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| ce_no | output | 1 | Chip enable, active low |
| we_no | output | 1 | Write enable, active low |
| re_no | output | 1 | Read enable, active low |
| io_o | output | 8 | Data bus output to the device |
| io_oe_o | output | 1 | Data bus output enable |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Erase succeeded |
| wp_o | output | 1 | Device reported write protection |
| timeout_o | output | 1 | Ready/busy handshake timed out |

## Verification
The erase is run with block numbers 0x3A5, 0x000 and 0x3FF, so the address byte packing is checked with mixed, all-zero and all-one fields. Status bytes 0xC0, 0xC1, 0x41 and 0x80 separate success from a reported error, from write protection and from a not-ready indication. Two busy-line faults are tried: a device that never drops busy and one that never releases it. Both must end through the timeout with no status read. A second start injected during the address cycles shows whether the latched block number or the completion count can be disturbed.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;
  localparam int unsigned BLK_W = 10;
  localparam logic [7:0] CMD_SETUP   = 8'h60;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_STATUS  = 8'h70;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_ADR0, S_ADR1, S_CONF, S_WAIT, S_STAT, S_READ, S_FIN
  } seq_state_e;
endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle #(
  parameter int unsigned WE_LO  = 2,
  parameter int unsigned RE_LO  = 2,
  parameter int unsigned STB_HI = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       rd_i,
  input  logic [7:0] io_i,
  output logic       we_no,
  output logic       re_no,
  output logic       active_o,
  output logic       last_o,
  output logic [7:0] rdata_o
);
  localparam int unsigned MAX_LO = (WE_LO > RE_LO) ? WE_LO : RE_LO;
  localparam int unsigned CW     = $clog2(MAX_LO + STB_HI + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lo_len;
  logic          act_q, rd_q, low;

  assign lo_len   = rd_q ? CW'(RE_LO) : CW'(WE_LO);
  assign low      = act_q && (cnt_q < lo_len);
  assign last_o   = act_q && (cnt_q == lo_len + CW'(STB_HI) - CW'(1));
  assign active_o = act_q;
  assign we_no    = !(low && !rd_q);
  assign re_no    = !(low && rd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      cnt_q   <= '0;
      rdata_o <= '0;
    end else if (go_i && !act_q) begin
      act_q <= 1'b1;
      rd_q  <= rd_i;
      cnt_q <= '0;
    end else if (act_q) begin
      // sample in the final low cycle of a read strobe
      if (rd_q && (cnt_q == lo_len - CW'(1))) rdata_o <= io_i;
      if (last_o) act_q <= 1'b0;
      else        cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/nand_busy_wait.sv
module nand_busy_wait #(
  parameter int unsigned TO_CYC = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic rdy_i,
  output logic ok_o,
  output logic to_o
);
  localparam int unsigned TW = $clog2(TO_CYC + 1);

  logic [1:0]    sync_q;
  logic          rdy_s, run_q, seen_q;
  logic [TW-1:0] cnt_q;

  assign rdy_s = sync_q[1];
  assign ok_o  = run_q && seen_q && rdy_s;
  assign to_o  = run_q && !ok_o && (cnt_q == TW'(TO_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      run_q  <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], rdy_i};
      if (arm_i) begin
        run_q  <= 1'b1;
        seen_q <= 1'b0;
        cnt_q  <= '0;
      end else if (run_q) begin
        cnt_q <= cnt_q + TW'(1);
        if (!rdy_s) seen_q <= 1'b1;
        if (ok_o || to_o) run_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nand_status_decode.sv
module nand_status_decode (
  input  logic [7:0] st_i,
  output logic       pass_o,
  output logic       wp_o
);
  logic unused_rsvd;
  assign unused_rsvd = ^st_i[5:1];
  assign pass_o = !st_i[0] && st_i[6];
  assign wp_o   = !st_i[7];
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nand_erase_pkg::*;
#(
  parameter int unsigned WE_LO  = 2,
  parameter int unsigned RE_LO  = 2,
  parameter int unsigned STB_HI = 2,
  parameter int unsigned TO_CYC = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             rdy_i,
  input  logic [7:0]       io_i,
  output logic             cle_o,
  output logic             ale_o,
  output logic             ce_no,
  output logic             we_no,
  output logic             re_no,
  output logic [7:0]       io_o,
  output logic             io_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             pass_o,
  output logic             wp_o,
  output logic             timeout_o
);
  seq_state_e       state_q, nxt_bus;
  logic             issued_q;
  logic [BLK_W-1:0] blk_q;
  logic             bus_state, bus_go, bus_act, bus_last;
  logic             arm, wait_ok, wait_to;
  logic [7:0]       rdata;
  logic             dec_pass, dec_wp;

  assign bus_state = (state_q == S_SETUP) || (state_q == S_ADR0) || (state_q == S_ADR1) ||
                     (state_q == S_CONF)  || (state_q == S_STAT) || (state_q == S_READ);
  assign bus_go    = bus_state && !issued_q && !bus_act;
  assign arm       = (state_q == S_WAIT) && !issued_q;

  always_comb begin
    unique case (state_q)
      S_SETUP: nxt_bus = S_ADR0;
      S_ADR0:  nxt_bus = S_ADR1;
      S_ADR1:  nxt_bus = S_CONF;
      S_CONF:  nxt_bus = S_WAIT;
      S_STAT:  nxt_bus = S_READ;
      default: nxt_bus = S_FIN;
    endcase
  end

  always_comb begin
    unique case (state_q)
      S_SETUP: io_o = CMD_SETUP;
      S_ADR0:  io_o = {blk_q[2:0], 5'b00000};
      S_ADR1:  io_o = {1'b0, blk_q[9:3]};
      S_CONF:  io_o = CMD_CONFIRM;
      S_STAT:  io_o = CMD_STATUS;
      default: io_o = 8'h00;
    endcase
  end

  assign cle_o   = (state_q == S_SETUP) || (state_q == S_CONF) || (state_q == S_STAT);
  assign ale_o   = (state_q == S_ADR0) || (state_q == S_ADR1);
  assign io_oe_o = cle_o || ale_o;
  assign ce_no   = (state_q == S_IDLE) || (state_q == S_FIN);
  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = (state_q == S_FIN);

  nand_bus_cycle #(
    .WE_LO (WE_LO),
    .RE_LO (RE_LO),
    .STB_HI(STB_HI)
  ) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (bus_go),
    .rd_i    (state_q == S_READ),
    .io_i    (io_i),
    .we_no   (we_no),
    .re_no   (re_no),
    .active_o(bus_act),
    .last_o  (bus_last),
    .rdata_o (rdata)
  );

  nand_busy_wait #(
    .TO_CYC(TO_CYC)
  ) u_wait (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .arm_i (arm),
    .rdy_i (rdy_i),
    .ok_o  (wait_ok),
    .to_o  (wait_to)
  );

  nand_status_decode u_dec (
    .st_i  (rdata),
    .pass_o(dec_pass),
    .wp_o  (dec_wp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      issued_q  <= 1'b0;
      blk_q     <= '0;
      pass_o    <= 1'b0;
      wp_o      <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          issued_q <= 1'b0;
          if (start_i) begin
            blk_q     <= blk_i;
            pass_o    <= 1'b0;
            wp_o      <= 1'b0;
            timeout_o <= 1'b0;
            state_q   <= S_SETUP;
          end
        end
        S_WAIT: begin
          if (!issued_q) issued_q <= 1'b1;
          if (wait_ok) begin
            issued_q <= 1'b0;
            state_q  <= S_STAT;
          end else if (wait_to) begin
            issued_q  <= 1'b0;
            timeout_o <= 1'b1;
            state_q   <= S_FIN;
          end
        end
        S_FIN: state_q <= S_IDLE;
        default: begin
          if (bus_go) issued_q <= 1'b1;
          if (bus_last) begin
            issued_q <= 1'b0;
            state_q  <= nxt_bus;
            if (state_q == S_READ) begin
              pass_o <= dec_pass;
              wp_o   <= dec_wp;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nand_erase_seq_chk.sv
module nand_erase_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cle_o,
  input logic       ale_o,
  input logic       ce_no,
  input logic       we_no,
  input logic       re_no,
  input logic       io_oe_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       pass_o,
  input logic       timeout_o,
  input logic [9:0] blk_q
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ce_no && we_no && re_no && !cle_o && !ale_o && !io_oe_o && !done_o));

  a_r2_latch_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));

  a_r2_ce_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no || !re_no) |-> !ce_no);

  a_r4_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));

  a_r5_read_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> !io_oe_o);

  a_r7_timeout_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !pass_o);

  a_r8_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(blk_q));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind nand_erase_seq nand_erase_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cle_o    (cle_o),
  .ale_o    (ale_o),
  .ce_no    (ce_no),
  .we_no    (we_no),
  .re_no    (re_no),
  .io_oe_o  (io_oe_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .pass_o   (pass_o),
  .timeout_o(timeout_o),
  .blk_q    (blk_q)
);

// File: tb/sim_nand_erase_seq.sv
`timescale 1ns/1ps
module sim_nand_erase_seq;
  localparam int WE_LO = 2, RE_LO = 3, STB_HI = 2, TO_CYC = 120;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [9:0] blk_i = '0;
  logic rdy_i = 1'b1;
  logic [7:0] io_i;
  logic cle_o, ale_o, ce_no, we_no, re_no, io_oe_o, busy_o, done_o, pass_o, wp_o, timeout_o;
  logic [7:0] io_o;

  always #2.5 clk = ~clk;

  nand_erase_seq #(.WE_LO(WE_LO), .RE_LO(RE_LO), .STB_HI(STB_HI), .TO_CYC(TO_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .blk_i(blk_i), .rdy_i(rdy_i), .io_i(io_i),
    .cle_o(cle_o), .ale_o(ale_o), .ce_no(ce_no), .we_no(we_no), .re_no(re_no), .io_o(io_o),
    .io_oe_o(io_oe_o), .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .wp_o(wp_o),
    .timeout_o(timeout_o));

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural device model and bus monitor
  logic [7:0] status = 8'hC0;
  bit never_busy = 0, stuck_busy = 0, stat_mode = 0;
  int dly = 0, ers = 0, busy_delay = 3, erase_len = 40;
  int we_lo = 0, re_lo = 0, ndone = 0, nreads = 0;
  logic [9:0] cap = '0;
  logic [9:0] got[$];

  assign io_i = (stat_mode && !re_no) ? status : 8'h00;

  always @(negedge clk) if (rst_n) begin
    if (dly > 0) begin
      dly--;
      if (dly == 0) begin rdy_i = 1'b0; ers = erase_len; end
    end else if (ers > 0) begin
      if (!stuck_busy) ers--;
      if (ers == 0) rdy_i = 1'b1;
    end
    chk(!(cle_o && ale_o), "R2 CLE/ALE exclusive", {cle_o, ale_o}, 0);
    chk(!((!we_no || !re_no) && ce_no), "R2 CE# low under strobe", ce_no, 0);
    chk(!(!we_no && !re_no), "R4 WE#/RE# exclusive", {we_no, re_no}, 3);
    if (!busy_o)
      chk(ce_no && we_no && re_no && !cle_o && !ale_o && !io_oe_o && !done_o,
          "R1 idle strobes", {ce_no, we_no, re_no, cle_o, ale_o, io_oe_o, done_o}, 7'b1110000);
    if (done_o) ndone++;
    if (!we_no) begin
      we_lo++;
      cap = {cle_o, ale_o, io_o};
      chk(io_oe_o, "R4 bus driven during WE# low", io_oe_o, 1);
    end else if (we_lo != 0) begin
      chk(we_lo == WE_LO, "R4 WE# low width", we_lo, WE_LO);
      got.push_back(cap);
      if (cap == {2'b10, 8'hD0} && !never_busy) dly = busy_delay;
      if (cap == {2'b10, 8'h70}) stat_mode = 1;
      if (cap == {2'b10, 8'h60}) stat_mode = 0;
      we_lo = 0;
    end
    if (!re_no) re_lo++;
    else if (re_lo != 0) begin
      chk(re_lo == RE_LO, "R5 RE# low width", re_lo, RE_LO);
      nreads++;
      re_lo = 0;
    end
  end

  task automatic run(input logic [9:0] a, input logic [7:0] st, input bit nb, input bit sb,
                     input int poke);
    bit to_exp, seen;
    logic [9:0] exp_q[$];
    got.delete(); ndone = 0; nreads = 0;
    status = st; never_busy = nb; stuck_busy = sb;
    to_exp = nb || sb;
    @(negedge clk); start_i = 1'b1; blk_i = a;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o && !pass_o && !wp_o && !timeout_o, "R9 flags cleared on start",
        {busy_o, pass_o, wp_o, timeout_o}, 4'b1000);
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      start_i = 1'b1; blk_i = a ^ 10'h155;
      @(negedge clk); start_i = 1'b0;
    end
    seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      if (done_o) seen = 1; else @(negedge clk);
    end
    chk(seen, "R9 done arrives", seen, 1);
    chk(timeout_o == to_exp, "R7 timeout flag", timeout_o, to_exp);
    chk(pass_o == (!to_exp && !st[0] && st[6]), "R6 pass flag", pass_o, !to_exp && !st[0] && st[6]);
    chk(wp_o == (!to_exp && !st[7]), "R6 protect flag", wp_o, !to_exp && !st[7]);
    @(negedge clk);
    chk(!done_o, "R9 done single cycle", done_o, 0);
    chk(timeout_o == to_exp && pass_o == (!to_exp && !st[0] && st[6]), "R9 flags held",
        {timeout_o, pass_o}, {to_exp, !to_exp && !st[0] && st[6]});
    if (sb) begin stuck_busy = 0; repeat (60) @(negedge clk); end
    repeat (3) @(negedge clk);
    chk(ndone == 1, "R8 one done per accepted start", ndone, 1);
    exp_q = '{{2'b10, 8'h60}, {2'b01, a[2:0], 5'b00000}, {2'b01, 1'b0, a[9:3]}, {2'b10, 8'hD0}};
    if (!to_exp) exp_q.push_back({2'b10, 8'h70});
    chk(got.size() == exp_q.size(), "R5 R7 bytes written", got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      chk(got[i] == exp_q[i], (i == 1 || i == 2) ? "R3 address byte" : "R2 R4 command byte",
          got[i], exp_q[i]);
    chk(nreads == (to_exp ? 0 : 1), "R5 status read count", nreads, to_exp ? 0 : 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ce_no && we_no && re_no && !cle_o && !ale_o && !io_oe_o && !busy_o && !done_o,
        "R1 reset state", {ce_no, we_no, re_no, busy_o}, 4'b1110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(10'h3A5, 8'hC0, 0, 0, 0);   // success
    run(10'h000, 8'hC1, 0, 0, 0);   // device error
    run(10'h3FF, 8'h41, 0, 0, 0);   // protected, error
    run(10'h155, 8'h80, 0, 0, 0);   // R6 not ready bit
    run(10'h2C3, 8'hC0, 1, 0, 0);   // R7 busy never seen
    run(10'h0F0, 8'hC0, 0, 1, 0);   // R7 busy never released
    run(10'h1A7, 8'hC0, 0, 0, 10);  // R8 start while busy
    run(10'h301, 8'hC1, 0, 0, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule